// File: doc/BRIEF.md
# Authentication Cipher Tick Sequencer

This block runs one mutual-authentication computation on an external stream cipher core. The core takes one byte and returns one nibble per tick. When the block is idle, a start pulse captures three 64-bit operands: a card nonce, a reader nonce and a secret key. The block then steps the core through 126 ticks. The first 56 ticks mix the operands into the cipher state. The remaining 70 ticks feed zero bytes, and the block collects the returned nibbles into a reader authenticator and a card authenticator.

Every tick is a one-clock strobe that carries the input byte. The block moves on only when the core answers with a ready pulse, and that pulse carries the output nibble. Byte k of an operand is bits [8k+7:8k]. The mixing schedule uses groups of seven ticks. Each group presents two consecutive card-nonce bytes (key bytes in the second half), each three times in a row, and then one reader-nonce byte.

Top module: `auth_tick_seq`

## Requirements
- R1: A start pulse seen while idle captures all three operands. The first tick strobe appears in the clock cycle right after that pulse. Later changes on the operand inputs have no effect on the run.
- R2: The tick strobe is high for exactly one cycle per tick. After a strobe, the block waits for ready and accepts it only in cycles after the strobe. A ready pulse in the strobe cycle, or while idle, does not advance the schedule and supplies no nibble. After an accepted ready, the next strobe comes in the following cycle.
- R3: Ticks 0 to 27 form four groups, g = 0..3, of seven bytes each. Each group is: card-nonce byte 2g three times, card-nonce byte 2g+1 three times, then reader-nonce byte g.
- R4: Ticks 28 to 55 form four groups, g = 0..3, of seven bytes each. Each group is: key byte 2g three times, key byte 2g+1 three times, then reader-nonce byte 4+g.
- R5: Ticks 56 to 125 present the byte 0x00.
- R6: Nibbles returned for ticks 0 to 55 are discarded. The nibbles of ticks 56 to 71 are packed first-in at the most significant end to form the 64-bit reader authenticator. Ticks 72 to 87 form the card authenticator in the same way. Nibbles of ticks 88 to 125 are discarded.
- R7: The done output is high for exactly one cycle: the cycle after the ready for tick 125 is accepted.
- R8: Both authenticator outputs are zero after reset. They change only in the done cycle and otherwise hold their values, including through a following run.
- R9: A start pulse while a run is in progress is ignored. A start pulse in the done cycle is accepted and begins a new run.
- R10: Busy is high from the cycle after an accepted start until the ready of tick 125 is accepted. It is low in the done cycle and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (taken when idle) |
| card_nonce | input | 64 | Card nonce, byte k at bits [8k+7:8k] |
| rdr_nonce | input | 64 | Reader nonce, byte k at bits [8k+7:8k] |
| secret_key | input | 64 | Secret key, byte k at bits [8k+7:8k] |
| core_tick | output | 1 | One-cycle tick strobe to the cipher core |
| core_byte | output | 8 | Input byte for the current tick |
| core_ready | input | 1 | Core acknowledge, carries the nibble |
| core_nibble | input | 4 | Output nibble of the acknowledged tick |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| auth_rdr | output | 64 | Reader authenticator |
| auth_card | output | 64 | Card authenticator |

## Verification
Two cases can fall in the same cycle. The completion cycle, where done rises and the authenticators update, can meet a new start. A core acknowledge can also meet the tick strobe itself. The bench raises start exactly in the done cycle and expects the new run's first strobe, carrying the new operands' first byte, in the next cycle, with the old authenticators held. It also pulses ready, with a corrupt nibble, in strobe cycles. A wrong advance would show as a byte schedule that slips against the model, and a wrongly kept nibble as a mismatched authenticator.

// File: rtl/auth_tick_pkg.sv
package auth_tick_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_TICK = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_e;

   function automatic int group_len(input int rep);
      return 2 * rep + 1;
   endfunction
endpackage

// File: rtl/auth_tick_ctrl.sv
module auth_tick_ctrl
   import auth_tick_pkg::*;
#(
   parameter int TOTAL_TICKS = 126,
   parameter int CW          = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          core_ready,
   output logic          core_tick,
   output logic          busy,
   output logic          done,
   output logic          load,
   output logic          take,
   output logic          finish,
   output logic [CW-1:0] tick_idx
);
   seq_state_e    state;
   logic [CW-1:0] cnt;
   logic          last;

   assign last      = (cnt == CW'(TOTAL_TICKS - 1));
   assign core_tick = (state == SEQ_TICK);
   assign busy      = (state != SEQ_IDLE);
   assign load      = (state == SEQ_IDLE) && start;
   assign take      = (state == SEQ_WAIT) && core_ready;
   assign finish    = take && last;
   assign tick_idx  = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state <= SEQ_TICK;
                  cnt   <= '0;
               end
            end
            SEQ_TICK: state <= SEQ_WAIT;
            SEQ_WAIT: begin
               if (core_ready) begin
                  if (last) begin
                     state <= SEQ_IDLE;
                     done  <= 1'b1;
                  end else begin
                     state <= SEQ_TICK;
                     cnt   <= cnt + 1'b1;
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_tick |=> !core_tick);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R2
   ready_only_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_tick && core_ready) |=> !core_tick);
endmodule

// File: rtl/auth_tick_sched.sv
module auth_tick_sched #(
   parameter int NONCE_BYTES = 8,
   parameter int REP         = 3,
   parameter int BYTE_W      = 8,
   parameter int MIX_TICKS   = 56,
   parameter int CW          = 7
) (
   input  logic [NONCE_BYTES*BYTE_W-1:0] card_q,
   input  logic [NONCE_BYTES*BYTE_W-1:0] rdr_q,
   input  logic [NONCE_BYTES*BYTE_W-1:0] key_q,
   input  logic [CW-1:0]                 tick_idx,
   output logic [BYTE_W-1:0]             core_byte
);
   localparam int GROUPS    = NONCE_BYTES / 2;
   localparam int GLEN      = auth_tick_pkg::group_len(REP);
   localparam int PHASE_LEN = GROUPS * GLEN;
   localparam int IW        = $clog2(NONCE_BYTES);

   logic [BYTE_W-1:0] card_b [NONCE_BYTES];
   logic [BYTE_W-1:0] rdr_b  [NONCE_BYTES];
   logic [BYTE_W-1:0] key_b  [NONCE_BYTES];

   for (genvar gi = 0; gi < NONCE_BYTES; gi++) begin : g_slice
      assign card_b[gi] = card_q[gi*BYTE_W +: BYTE_W];
      assign rdr_b[gi]  = rdr_q[gi*BYTE_W +: BYTE_W];
      assign key_b[gi]  = key_q[gi*BYTE_W +: BYTE_W];
   end

   always_comb begin
      int t, ph, w, g, s;
      logic [IW-1:0] sel;
      t  = int'(tick_idx);
      ph = t / PHASE_LEN;
      w  = t % PHASE_LEN;
      g  = w / GLEN;
      s  = w % GLEN;
      core_byte = '0;
      sel       = '0;
      if (t < MIX_TICKS) begin
         if (s == GLEN - 1) begin
            sel       = IW'(ph * GROUPS + g);
            core_byte = rdr_b[sel];
         end else begin
            sel       = IW'(2 * g + s / REP);
            core_byte = (ph == 0) ? card_b[sel] : key_b[sel];
         end
      end
   end
endmodule

// File: rtl/auth_tick_pack.sv
module auth_tick_pack #(
   parameter int NIB_W         = 4,
   parameter int AUTH_NIBS     = 16,
   parameter int MIX_TICKS     = 56,
   parameter int CW            = 7,
   parameter bit FIRST_AT_MSB  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       take,
   input  logic                       finish,
   input  logic [CW-1:0]              tick_idx,
   input  logic [NIB_W-1:0]           nibble,
   output logic [AUTH_NIBS*NIB_W-1:0] auth_rdr,
   output logic [AUTH_NIBS*NIB_W-1:0] auth_card
);
   localparam int AW  = AUTH_NIBS * NIB_W;
   localparam int ACW = 2 * AW;

   logic [ACW-1:0] acc, acc_nx;
   logic           in_win;

   assign in_win = (tick_idx >= CW'(MIX_TICKS)) &&
                   (tick_idx <  CW'(MIX_TICKS + 2 * AUTH_NIBS));

   if (FIRST_AT_MSB) begin : g_msb
      always_comb begin
         acc_nx = acc;
         if (take && in_win) acc_nx = {acc[ACW-NIB_W-1:0], nibble};
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            auth_rdr  <= '0;
            auth_card <= '0;
         end else if (finish) begin
            auth_rdr  <= acc_nx[ACW-1:AW];
            auth_card <= acc_nx[AW-1:0];
         end
      end
   end else begin : g_lsb
      always_comb begin
         acc_nx = acc;
         if (take && in_win) acc_nx = {nibble, acc[ACW-1:NIB_W]};
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            auth_rdr  <= '0;
            auth_card <= '0;
         end else if (finish) begin
            auth_rdr  <= acc_nx[AW-1:0];
            auth_card <= acc_nx[ACW-1:AW];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else        acc <= acc_nx;
   end

   // R6
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(acc));
endmodule

// File: rtl/auth_tick_seq.sv
module auth_tick_seq #(
   parameter int NONCE_BYTES = 8,
   parameter int REP         = 3,
   parameter int BYTE_W      = 8,
   parameter int NIB_W       = 4,
   parameter int GEN_TICKS   = 70,
   parameter int AUTH_NIBS   = 16,
   parameter bit FIRST_AT_MSB = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [NONCE_BYTES*BYTE_W-1:0] card_nonce,
   input  logic [NONCE_BYTES*BYTE_W-1:0] rdr_nonce,
   input  logic [NONCE_BYTES*BYTE_W-1:0] secret_key,
   output logic                          core_tick,
   output logic [BYTE_W-1:0]             core_byte,
   input  logic                          core_ready,
   input  logic [NIB_W-1:0]              core_nibble,
   output logic                          busy,
   output logic                          done,
   output logic [AUTH_NIBS*NIB_W-1:0]    auth_rdr,
   output logic [AUTH_NIBS*NIB_W-1:0]    auth_card
);
   localparam int OPW         = NONCE_BYTES * BYTE_W;
   localparam int GLEN        = auth_tick_pkg::group_len(REP);
   localparam int MIX_TICKS   = NONCE_BYTES * GLEN;
   localparam int TOTAL_TICKS = MIX_TICKS + GEN_TICKS;
   localparam int CW          = $clog2(TOTAL_TICKS);

   if (NONCE_BYTES < 2 || NONCE_BYTES % 2 != 0) begin : g_bad_bytes
      $error("NONCE_BYTES must be even and at least 2");
   end
   if (REP < 1) begin : g_bad_rep
      $error("REP must be at least 1");
   end
   if (GEN_TICKS < 2 * AUTH_NIBS) begin : g_bad_gen
      $error("GEN_TICKS too short for both authenticators");
   end

   logic [OPW-1:0] card_q, rdr_q, key_q;
   logic           load, take, finish;
   logic [CW-1:0]  tick_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         card_q <= '0;
         rdr_q  <= '0;
         key_q  <= '0;
      end else if (load) begin
         card_q <= card_nonce;
         rdr_q  <= rdr_nonce;
         key_q  <= secret_key;
      end
   end

   auth_tick_ctrl #(.TOTAL_TICKS(TOTAL_TICKS), .CW(CW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .core_ready(core_ready),
      .core_tick(core_tick), .busy(busy), .done(done), .load(load),
      .take(take), .finish(finish), .tick_idx(tick_idx)
   );

   auth_tick_sched #(.NONCE_BYTES(NONCE_BYTES), .REP(REP), .BYTE_W(BYTE_W),
                     .MIX_TICKS(MIX_TICKS), .CW(CW)) u_sched (
      .card_q(card_q), .rdr_q(rdr_q), .key_q(key_q),
      .tick_idx(tick_idx), .core_byte(core_byte)
   );

   auth_tick_pack #(.NIB_W(NIB_W), .AUTH_NIBS(AUTH_NIBS), .MIX_TICKS(MIX_TICKS),
                    .CW(CW), .FIRST_AT_MSB(FIRST_AT_MSB)) u_pack (
      .clk(clk), .rst_n(rst_n), .take(take), .finish(finish),
      .tick_idx(tick_idx), .nibble(core_nibble),
      .auth_rdr(auth_rdr), .auth_card(auth_card)
   );

   // R8
   auth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(auth_rdr) && $stable(auth_card)));
   // R9
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(card_q) && $stable(rdr_q) && $stable(key_q)));
   // R5
   gen_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_tick && tick_idx >= CW'(MIX_TICKS)) |-> (core_byte == '0));
   // R1
   first_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> core_tick);
endmodule

// File: tb/auth_tick_seq_tb.sv
module auth_tick_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] card_nonce = 64'h0706050403020100;
   logic [63:0] rdr_nonce  = 64'h8786858483828180;
   logic [63:0] secret_key = 64'hF7E6D5C4B3A29180;
   logic        core_tick;
   logic [7:0]  core_byte;
   logic        core_ready = 1'b0;
   logic [3:0]  core_nibble = 4'h0;
   logic        busy, done;
   logic [63:0] auth_rdr, auth_card;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   auth_tick_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .card_nonce(card_nonce), .rdr_nonce(rdr_nonce), .secret_key(secret_key),
      .core_tick(core_tick), .core_byte(core_byte),
      .core_ready(core_ready), .core_nibble(core_nibble),
      .busy(busy), .done(done), .auth_rdr(auth_rdr), .auth_card(auth_card)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // One full computation; the model is a list of expected bytes plus the
   // nibbles this bench hands back in generation ticks.
   task automatic run(input bit pre, input bit stray, input bit busy_start,
                      input bit chain, input int seed);
      logic [7:0]   q[$];
      logic [127:0] exp_acc = '0;
      logic [63:0]  old_r = auth_rdr;
      logic [63:0]  old_c = auth_card;
      logic [63:0]  ops[2];
      ops[0] = card_nonce;
      ops[1] = secret_key;
      for (int ph = 0; ph < 2; ph++)
         for (int g = 0; g < 4; g++) begin
            for (int r = 0; r < 3; r++) q.push_back(ops[ph][16*g +: 8]);
            for (int r = 0; r < 3; r++) q.push_back(ops[ph][16*g+8 +: 8]);
            q.push_back(rdr_nonce[8*(4*ph+g) +: 8]);
         end
      for (int i = 0; i < 70; i++) q.push_back(8'h00);

      if (!pre) begin
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int t = 0; t < 126; t++) begin
         logic [3:0] nib;
         string req;
         req = (t < 28) ? "R3" : (t < 56) ? "R4" : "R5";
         chk(core_tick === 1'b1, (t == 0) ? "R1" : "R2", "strobe", 64'(core_tick), 64'd1);
         chk(core_byte === q[t], req, "byte", 64'(core_byte), 64'(q[t]));
         if (t == 0 || t == 125) chk(busy === 1'b1, "R10", "busy in run", 64'(busy), 64'd1);
         nib = 4'((t * 5 + seed) ^ (t >> 2));
         if (t >= 56 && t < 88) exp_acc = {exp_acc[123:0], nib};
         if (stray && (t % 9 == 0)) begin
            core_ready  = 1'b1;
            core_nibble = ~nib;
         end
         if (busy_start && t == 30) begin
            start      = 1'b1;
            card_nonce = ~card_nonce;
            rdr_nonce  = rdr_nonce ^ 64'h5A5A5A5A5A5A5A5A;
            secret_key = {secret_key[31:0], secret_key[63:32]};
         end
         @(negedge clk);
         core_ready = 1'b0;
         start      = 1'b0;
         chk(core_tick === 1'b0, "R2", "strobe low in wait", 64'(core_tick), 64'd0);
         for (int e = 0; e < (t + seed) % 3; e++) @(negedge clk);
         if (t == 100) begin
            chk(auth_rdr === old_r, "R8", "rdr held in run", auth_rdr, old_r);
            chk(auth_card === old_c, "R8", "card held in run", auth_card, old_c);
         end
         core_ready  = 1'b1;
         core_nibble = nib;
         @(negedge clk);
         core_ready = 1'b0;
      end
      chk(done === 1'b1, "R7", "done after last tick", 64'(done), 64'd1);
      chk(busy === 1'b0, "R10", "busy in done cycle", 64'(busy), 64'd0);
      chk(core_tick === 1'b0, "R7", "no strobe at done", 64'(core_tick), 64'd0);
      chk(auth_rdr === exp_acc[127:64], "R6", "reader auth", auth_rdr, exp_acc[127:64]);
      chk(auth_card === exp_acc[63:0], "R6", "card auth", auth_card, exp_acc[63:0]);
      if (chain) begin
         card_nonce = card_nonce ^ 64'h1122334455667788;
         rdr_nonce  = {rdr_nonce[7:0], rdr_nonce[63:8]};
         secret_key = secret_key + 64'h0101010101010101;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(done === 1'b0, "R9", "done single cycle", 64'(done), 64'd0);
      end else begin
         @(negedge clk);
         chk(done === 1'b0, "R7", "done single cycle", 64'(done), 64'd0);
         chk(auth_rdr === exp_acc[127:64], "R8", "rdr held after done", auth_rdr, exp_acc[127:64]);
         chk(busy === 1'b0, "R10", "idle after done", 64'(busy), 64'd0);
         repeat (2) @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(core_tick === 1'b0, "R8", "reset strobe", 64'(core_tick), 64'd0);
      chk(done === 1'b0, "R8", "reset done", 64'(done), 64'd0);
      chk(busy === 1'b0, "R10", "reset busy", 64'(busy), 64'd0);
      chk(auth_rdr === 64'd0, "R8", "reset rdr", auth_rdr, 64'd0);
      chk(auth_card === 64'd0, "R8", "reset card", auth_card, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // ready while idle must do nothing
      core_ready  = 1'b1;
      core_nibble = 4'hF;
      repeat (2) @(negedge clk);
      core_ready = 1'b0;
      chk(core_tick === 1'b0, "R2", "idle ready no strobe", 64'(core_tick), 64'd0);
      chk(done === 1'b0, "R2", "idle ready no done", 64'(done), 64'd0);
      chk(busy === 1'b0, "R2", "idle ready no busy", 64'(busy), 64'd0);
      @(negedge clk);

      run(1'b0, 1'b0, 1'b0, 1'b0, 0);
      run(1'b0, 1'b1, 1'b0, 1'b0, 1);
      run(1'b0, 1'b0, 1'b1, 1'b1, 2);
      run(1'b1, 1'b1, 1'b0, 1'b0, 5);
      card_nonce = 64'hFFFFFFFFFFFFFFFF;
      rdr_nonce  = 64'h0;
      secret_key = 64'h8000000000000001;
      run(1'b0, 1'b0, 1'b0, 1'b0, 7);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule